// File: doc/BRIEF.md
# Clocked Graph Reachability Flood Array

This block holds a small, fixed graph as logic and finds the vertices that can be reached from a chosen start vertex. Each vertex has one register that records whether it has been reached. Each edge is a wire from its source vertex's register into the OR gate in front of its destination vertex's register. Once a run starts, the set of reached vertices spreads one hop on every clock. This is a breadth-first flood with no queue and no memory. The edges are fixed when the design is built, from a parameter list of edges. A mode parameter sets whether each edge works in one direction only or in both.

The user applies a synchronous clear, then pulses a start input with a vertex index. After that the block reports three things: the vector of reached vertices, a depth counter equal to the number of hops flooded so far, and a done flag. The flag rises when every vertex has been reached or when the flood stops growing. After that the result stays fixed until the next clear. An index that names no vertex raises an error flag and starts nothing.

Top module: `flood_reach_top`

## Requirements
- R1: On the clock edge where `clr` is high, the reached vector, `done`, `depth` and `root_err` all become zero.
- R2: With the block idle after a clear, a `start` pulse with `root_idx` below `N_VERT` makes the reached vector hold exactly bit `root_idx` one clock later, with `depth` equal to 0.
- R3: On each clock of a run, a vertex's reached bit becomes the OR of its own bit and the bits of every vertex with an edge into it. Each edge entry is `2*FIELD_W` bits wide: the upper `FIELD_W` bits give the source index and the lower `FIELD_W` bits give the destination index.
- R4: A vertex at hop distance k from the start vertex is first reported reached k clocks after the start edge. While the set is still growing, `depth` equals k at that point.
- R5: `done` rises on the same edge where the reached vector becomes all ones.
- R6: If an edge adds no new vertex before all vertices are reached, `done` rises on that edge. `depth` stays equal to the largest hop distance reached, and the reached vector stays unchanged from then on.
- R7: A `start` pulse during a run, or after `done`, changes no output until `clr` is applied.
- R8: A `start` pulse with `root_idx` of `N_VERT` or more leaves the reached vector at zero, sets `root_err` and keeps `done` low. Later start pulses are ignored until `clr`.
- R9: With `DIRECTED` set to 1, an edge carries the reached state only from its source to its destination. With `DIRECTED` set to 0, it carries it both ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of all state |
| start | input | 1 | Start pulse, taken only when idle |
| root_idx | input | IDX_W | Index of the start vertex |
| visited | output | N_VERT | One reached flag per vertex |
| done | output | 1 | Run finished: all reached or no growth |
| depth | output | DEPTH_W | Hops flooded so far |
| root_err | output | 1 | Start index was out of range |

## Verification
A wrong edge or a wrong OR term in front of a vertex shows up at the ports one clock after the flood reaches its source. At that point the reached vector holds a bit too many or too few compared with the hop distances computed in the bench. If `done` or `depth` are handled wrongly, the mistake appears on the edge where the set stops growing, or on the following edge. At that edge the flag rises too early or too late, or the counter keeps moving after it should freeze. The bench drives the same stimulus into a two-way and a one-way instance built from the same edge list. Directional mistakes therefore appear as a mismatch on the one-way instance within a few clocks of start.

// File: rtl/flood_pkg.sv
package flood_pkg;
    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_RUN  = 2'd1,
        FL_DONE = 2'd2,
        FL_BAD  = 2'd3
    } flood_st_e;
endpackage

// File: rtl/flood_adj.sv
// Expands the edge list into one in-neighbour mask per vertex.
// Bit dst*N_VERT+src is set when an edge carries state from src into dst.
module flood_adj #(
    parameter int N_VERT   = 12,
    parameter int N_EDGE   = 12,
    parameter int FIELD_W  = 4,
    parameter bit DIRECTED = 1'b0,
    parameter logic [2*FIELD_W*N_EDGE-1:0] EDGE_LIST = '0
) (
    output logic [N_VERT*N_VERT-1:0] in_mask_o
);
    localparam int ENT_W = 2 * FIELD_W;

    function automatic bit edge_hit(input int dst, input int src);
        bit hit;
        hit = 1'b0;
        for (int k = 0; k < N_EDGE; k++) begin
            int s;
            int d;
            s = int'(EDGE_LIST[k*ENT_W+FIELD_W +: FIELD_W]);
            d = int'(EDGE_LIST[k*ENT_W +: FIELD_W]);
            if (s == src && d == dst) hit = 1'b1;
            if (!DIRECTED && s == dst && d == src) hit = 1'b1;
        end
        return hit;
    endfunction

    for (genvar gd = 0; gd < N_VERT; gd++) begin : g_dst
        for (genvar gs = 0; gs < N_VERT; gs++) begin : g_src
            localparam bit HIT = edge_hit(gd, gs);
            assign in_mask_o[gd*N_VERT+gs] = HIT;
        end
    end
endmodule

// File: rtl/flood_cell.sv
// Next reached value of one vertex: hold own flag, OR in all in-neighbours.
module flood_cell #(
    parameter int N_VERT = 12,
    parameter int IDX    = 0
) (
    input  logic [N_VERT-1:0] vis_i,
    input  logic [N_VERT-1:0] in_mask_i,
    output logic              nxt_o
);
    assign nxt_o = vis_i[IDX] | (|(vis_i & in_mask_i));
endmodule

// File: rtl/flood_reach_top.sv
module flood_reach_top
    import flood_pkg::*;
#(
    parameter int N_VERT   = 12,
    parameter int N_EDGE   = 12,
    parameter int FIELD_W  = 4,
    parameter bit DIRECTED = 1'b0,
    parameter logic [2*FIELD_W*N_EDGE-1:0] EDGE_LIST = {
        8'h01, 8'h12, 8'h23, 8'h04, 8'h45, 8'h53,
        8'h36, 8'h67, 8'h18, 8'h89, 8'h9A, 8'hAB
    },
    localparam int IDX_W   = (N_VERT > 1) ? $clog2(N_VERT) : 1,
    localparam int DEPTH_W = $clog2(N_VERT + 1)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               start,
    input  logic [IDX_W-1:0]   root_idx,
    output logic [N_VERT-1:0]  visited,
    output logic               done,
    output logic [DEPTH_W-1:0] depth,
    output logic               root_err
);
    typedef struct packed {
        flood_st_e          st;
        logic [N_VERT-1:0]  vis;
        logic [DEPTH_W-1:0] depth;
    } fl_state_t;

    fl_state_t state_d, state_q;

    logic [N_VERT*N_VERT-1:0] in_mask;
    logic [N_VERT-1:0]        grow_vis;
    logic [N_VERT-1:0]        seed_vec;
    logic                     root_ok;

    flood_adj #(
        .N_VERT   (N_VERT),
        .N_EDGE   (N_EDGE),
        .FIELD_W  (FIELD_W),
        .DIRECTED (DIRECTED),
        .EDGE_LIST(EDGE_LIST)
    ) u_adj (
        .in_mask_o(in_mask)
    );

    for (genvar gv = 0; gv < N_VERT; gv++) begin : g_cell
        flood_cell #(
            .N_VERT(N_VERT),
            .IDX   (gv)
        ) u_cell (
            .vis_i    (state_q.vis),
            .in_mask_i(in_mask[gv*N_VERT +: N_VERT]),
            .nxt_o    (grow_vis[gv])
        );
    end

    always_comb begin
        seed_vec    = '0;
        seed_vec[0] = 1'b1;
        seed_vec    = seed_vec << root_idx;
        root_ok     = (int'(root_idx) < N_VERT);

        state_d = state_q;
        case (state_q.st)
            FL_IDLE: begin
                if (start) begin
                    if (root_ok) begin
                        state_d.vis   = seed_vec;
                        state_d.depth = '0;
                        state_d.st    = (&seed_vec) ? FL_DONE : FL_RUN;
                    end else begin
                        state_d.st = FL_BAD;
                    end
                end
            end
            FL_RUN: begin
                if (grow_vis != state_q.vis) begin
                    state_d.vis   = grow_vis;
                    state_d.depth = state_q.depth + 1'b1;
                    if (&grow_vis) state_d.st = FL_DONE;
                end else begin
                    state_d.st = FL_DONE;
                end
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= '{st: FL_IDLE, vis: '0, depth: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign visited  = state_q.vis;
    assign depth    = state_q.depth;
    assign done     = (state_q.st == FL_DONE);
    assign root_err = (state_q.st == FL_BAD);
endmodule

// File: rtl/flood_reach_chk.sv
module flood_reach_chk #(
    parameter int N_VERT  = 12,
    parameter int IDX_W   = 4,
    parameter int DEPTH_W = 4
) (
    input logic               clk,
    input logic               clr,
    input logic               start,
    input logic [IDX_W-1:0]   root_idx,
    input logic [N_VERT-1:0]  visited,
    input logic               done,
    input logic [DEPTH_W-1:0] depth,
    input logic               root_err
);
    AST_CLEAR_EMPTY: assert property (@(posedge clk)
        clr |=> (visited == '0 && !done && !root_err && depth == '0)); // R1

    AST_START_SEED: assert property (@(posedge clk) disable iff (clr)
        (start && visited == '0 && !root_err && !done && int'(root_idx) < N_VERT)
        |=> ($onehot(visited) && depth == '0)); // R2

    AST_MONOTONE: assert property (@(posedge clk) disable iff (clr)
        (!clr) |=> ((visited & $past(visited)) == $past(visited))); // R3

    AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (clr)
        (!done && !root_err && visited != '0)
        |=> (done || depth == DEPTH_W'($past(depth) + 1'b1))); // R4

    AST_FULL_DONE: assert property (@(posedge clk) disable iff (clr)
        (&visited) |-> done); // R5

    AST_FROZEN: assert property (@(posedge clk) disable iff (clr)
        done |=> (done && $stable(visited) && $stable(depth))); // R6

    AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (clr)
        root_err |-> (visited == '0 && !done)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (clr)
        root_err |=> root_err); // R8
endmodule

bind flood_reach_top flood_reach_chk #(
    .N_VERT (N_VERT),
    .IDX_W  (IDX_W),
    .DEPTH_W(DEPTH_W)
) u_chk (
    .clk     (clk),
    .clr     (clr),
    .start   (start),
    .root_idx(root_idx),
    .visited (visited),
    .done    (done),
    .depth   (depth),
    .root_err(root_err)
);

// File: tb/flood_reach_top_bench.sv
module flood_reach_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 12;
    localparam int NE     = 12;
    localparam int FW     = 4;
    localparam int IW     = 4;
    localparam int DW     = 4;
    localparam int INF    = 1000;
    localparam logic [2*FW*NE-1:0] EDGES = {
        8'h01, 8'h12, 8'h23, 8'h04, 8'h45, 8'h53,
        8'h36, 8'h67, 8'h18, 8'h89, 8'h9A, 8'hAB
    };

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          start = 1'b0;
    logic [IW-1:0] root_idx = '0;

    logic [N-1:0]  vis_u, vis_d;
    logic          done_u, done_d, err_u, err_d;
    logic [DW-1:0] dep_u, dep_d;

    int n_checks = 0;
    int n_fail   = 0;
    int dist_u[N];
    int dist_d[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    flood_reach_top #(.N_VERT(N), .N_EDGE(NE), .FIELD_W(FW), .DIRECTED(1'b0), .EDGE_LIST(EDGES))
    u_flood_reach_top (
        .clk(clk), .clr(clr), .start(start), .root_idx(root_idx),
        .visited(vis_u), .done(done_u), .depth(dep_u), .root_err(err_u)
    );

    flood_reach_top #(.N_VERT(N), .N_EDGE(NE), .FIELD_W(FW), .DIRECTED(1'b1), .EDGE_LIST(EDGES))
    u_flood_reach_top_dir (
        .clk(clk), .clr(clr), .start(start), .root_idx(root_idx),
        .visited(vis_d), .done(done_d), .depth(dep_d), .root_err(err_d)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hop distances from the root, by repeated relaxation over the edge list.
    task automatic calc_dist(input int root, input bit dir, output int d[N]);
        for (int v = 0; v < N; v++) d[v] = INF;
        d[root] = 0;
        for (int r = 0; r < N; r++) begin
            for (int k = 0; k < NE; k++) begin
                int s;
                int t;
                s = int'(EDGES[k*2*FW+FW +: FW]);
                t = int'(EDGES[k*2*FW +: FW]);
                if (d[s] + 1 < d[t]) d[t] = d[s] + 1;
                if (!dir && d[t] + 1 < d[s]) d[s] = d[t] + 1;
            end
        end
    endtask

    task automatic check_state(input string tag, input int k, input logic [N-1:0] vis,
                               input logic dn, input logic [DW-1:0] dep, input int d[N]);
        logic [N-1:0] exp_vis;
        int ecc;
        bit full;
        int exp_dep;
        bit exp_done;
        exp_vis = '0;
        ecc = 0;
        full = 1'b1;
        for (int v = 0; v < N; v++) begin
            if (d[v] <= k) exp_vis[v] = 1'b1;
            if (d[v] == INF) full = 1'b0;
            else if (d[v] > ecc) ecc = d[v];
        end
        exp_dep  = (k < ecc) ? k : ecc;
        exp_done = full ? (k >= ecc) : (k >= ecc + 1);
        chk(vis == exp_vis, {tag, " R3 R4 visited"}, int'(vis), int'(exp_vis));
        chk(int'(dep) == exp_dep, {tag, " R4 R6 depth"}, int'(dep), exp_dep);
        chk(dn == exp_done, {tag, " R5 R6 done"}, int'(dn), int'(exp_done));
    endtask

    task automatic do_clear();
        clr = 1'b1;
        step();
        clr = 1'b0;
        chk(vis_u == '0 && vis_d == '0, "R1 visited zero", int'(vis_u | vis_d), 0);
        chk(!done_u && !done_d && !err_u && !err_d, "R1 flags zero",
            int'({done_u, done_d, err_u, err_d}), 0);
        chk(dep_u == '0 && dep_d == '0, "R1 depth zero", int'(dep_u | dep_d), 0);
    endtask

    task automatic run_case(input int root);
        int maxk;
        logic [N-1:0] hold_u, hold_d;
        calc_dist(root, 1'b0, dist_u);
        calc_dist(root, 1'b1, dist_d);
        do_clear();
        start = 1'b1;
        root_idx = IW'(root);
        step();
        start = 1'b0;
        chk(vis_u == (N'(1) << root) && dep_u == '0, "R2 seed",
            int'(vis_u), int'(N'(1) << root));
        maxk = N + 1;
        for (int k = 0; k <= maxk; k++) begin
            check_state("undirected", k, vis_u, done_u, dep_u, dist_u);
            check_state("R9 directed", k, vis_d, done_d, dep_d, dist_d);
            if (k < maxk) step();
        end
        hold_u = vis_u;
        hold_d = vis_d;
        start = 1'b1;
        root_idx = IW'((root + 5) % N);
        step();
        start = 1'b0;
        step();
        chk(vis_u == hold_u && done_u, "R7 restart ignored undirected", int'(vis_u), int'(hold_u));
        chk(vis_d == hold_d && done_d, "R7 restart ignored directed", int'(vis_d), int'(hold_d));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        @(negedge clk);
        do_clear();

        // Directed corners: full cover, a sink vertex, a mid-graph vertex
        run_case(0);
        run_case(7);
        run_case(11);
        run_case(3);

        // R7: start during a run (undirected from 0 runs 5 hops)
        do_clear();
        start = 1'b1;
        root_idx = IW'(0);
        step();
        root_idx = IW'(9);
        step();
        start = 1'b0;
        chk(vis_u == 12'h013, "R7 start mid-run ignored", int'(vis_u), 'h013);

        // R8: out-of-range root
        do_clear();
        start = 1'b1;
        root_idx = IW'(13);
        step();
        start = 1'b0;
        chk(vis_u == '0 && vis_d == '0, "R8 visited stays zero", int'(vis_u | vis_d), 0);
        chk(err_u && err_d, "R8 root_err set", int'({err_u, err_d}), 3);
        chk(!done_u && !done_d, "R8 done low", int'({done_u, done_d}), 0);
        start = 1'b1;
        root_idx = IW'(2);
        step();
        start = 1'b0;
        step();
        chk(vis_u == '0 && err_u, "R8 later start ignored", int'(vis_u), 0);
        do_clear();

        // Random roots
        for (int i = 0; i < 20; i++) begin
            run_case(int'($urandom % N));
        end

        finish_run();
    end
endmodule